// File: doc/BRIEF.md
# Shared Accumulating Shift Buffer

This block is one wide bit buffer that several serial datapath units of a lattice-cryptography coprocessor take turns to use. Each unit reads a run of consecutive 64-bit memory words into the buffer. It then takes bit fields of a chosen width off the bottom, one after another, as its arithmetic needs them. The units never run at the same time, so a single buffer sized for the largest of them replaces one private shift register per unit.

A two-bit select input picks the unit that owns the buffer. Only that unit's push, pop, field-width and word inputs have any effect. Each unit has its own window length, and the buffer never holds more bits than that window. A push appends a whole word directly above the bits already held. A pop hands out the lowest N bits and moves the rest down. When both happen in the same cycle, the pop is applied first. When ownership changes, the buffer is emptied.

Acknowledge outputs tell the owning unit in the same cycle whether its push or pop was taken. The fill level output reports how many bits are held.

Top module: `acc_shift_buf`

## Requirements
- R1: While `rst` is high, `push_ack` and `pop_ack` are low. After reset, `fill_level` reads 0 and a 1-bit pop is refused.
- R2: Only the client chosen by `client_sel` (0 to 3) can act. The push, pop, length and word inputs of the other clients have no effect on acknowledges, field or fill level.
- R3: In a cycle where `client_sel` differs from its value in the previous cycle, both requests are refused. `fill_level` is 0 in the next cycle, and the held bits are discarded.
- R4: An accepted push places the 64-bit word so that its bit 0 lies directly above the highest held bit. `fill_level` grows by 64.
- R5: A push is refused when the window length minus the fill level (after any same-cycle pop) is below 64. A refused push leaves contents and level as they were.
- R6: For an accepted pop of N bits, `field_out[N-1:0]` holds the N lowest held bits, with bit 0 being the lowest, and `field_out` bits above N are 0. Those bits are removed, the rest move down by N, and `fill_level` drops by N.
- R7: A pop is refused when N is 0, when N is above 64, or when the fill level is below N. The contents are then unchanged.
- R8: When a push and a pop are both requested in one cycle, the pop is applied first. The push is judged on the space left after the pop, and the word lands directly above the bits that remain.
- R9: The window lengths are 64 bits for client 0 (rounding adder), 320 for client 1 (packing adder), 320 for client 2 (byte-string to polynomial converter) and 676 for client 3 (multiplier, the whole buffer).
- R10: `fill_level` always equals the number of held bits. `push_ack` and `pop_ack` answer in the same cycle as the request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| client_sel | input | 2 | Index of the client that owns the buffer |
| push_req | input | 4 | Push request, one bit per client |
| pop_req | input | 4 | Pop request, one bit per client |
| pop_len | input | 28 | Field width N per client, 7 bits each, client k at bits 7k+6:7k |
| push_word | input | 256 | Word to append per client, client k at bits 64k+63:64k |
| field_out | output | 64 | Lowest `pop_len` bits of the buffer for the selected client, zero above |
| pop_ack | output | 1 | The pop is accepted this cycle |
| push_ack | output | 1 | The push is accepted this cycle |
| fill_level | output | 10 | Number of bits held |

## Verification
The buffer is driven with directed sequences for each client. These fill the window exactly to its limit and then one word past it, which separates a correct window length from one that is off by a word. A simultaneous pop and push is tried both where the pop frees just enough space and where it does not, which exposes a push-before-pop ordering. Pop widths of 0, 65 and widths larger than the fill level are also tried. For the multiplier, a 28-bit pop followed by a push lands exactly on 676 bits. Long runs of random push, pop and width traffic follow, with the other clients' inputs toggling randomly at the same time, and every field is compared against a bit queue. Select switches are placed while data is held, to show that the contents are discarded.

// File: rtl/ssb_pkg.sv
`timescale 1ns/1ps
package ssb_pkg;

    localparam int SSB_WORD_W  = 64;
    localparam int SSB_BUF_W   = 676;
    localparam int SSB_CLIENTS = 4;
    localparam int SSB_SEL_W   = $clog2(SSB_CLIENTS);
    localparam int SSB_LEN_W   = $clog2(SSB_WORD_W + 1);
    localparam int SSB_LVL_W   = $clog2(SSB_BUF_W + 1);

    localparam int SSB_WIN_ROUND = 64;
    localparam int SSB_WIN_PACK  = 320;
    localparam int SSB_WIN_B2P   = 320;
    localparam int SSB_WIN_MULT  = SSB_BUF_W;

    typedef enum logic [SSB_SEL_W-1:0] {
        CL_ROUND,
        CL_PACK,
        CL_B2P,
        CL_MULT
    } client_e;

    // Request of the client that currently owns the buffer
    typedef struct packed {
        logic                  push;
        logic                  pop;
        logic [SSB_LEN_W-1:0]  len;
        logic [SSB_WORD_W-1:0] word;
    } client_req_t;

    // Decided update handed from occupancy control to storage
    typedef struct packed {
        logic                  clear;
        logic                  pop_go;
        logic                  push_go;
        logic [SSB_LEN_W-1:0]  len;
        logic [SSB_LVL_W-1:0]  base;
        logic [SSB_WORD_W-1:0] word;
    } step_t;

    function automatic logic [SSB_LVL_W:0] window_of(client_e c);
        logic [SSB_LVL_W:0] w;
        case (c)
            CL_ROUND: w = (SSB_LVL_W+1)'(SSB_WIN_ROUND);
            CL_PACK:  w = (SSB_LVL_W+1)'(SSB_WIN_PACK);
            CL_B2P:   w = (SSB_LVL_W+1)'(SSB_WIN_B2P);
            default:  w = (SSB_LVL_W+1)'(SSB_WIN_MULT);
        endcase
        return w;
    endfunction

    function automatic logic [SSB_WORD_W-1:0] low_mask(logic [SSB_LEN_W-1:0] n);
        logic [SSB_WORD_W-1:0] m;
        if (int'(n) >= SSB_WORD_W)
            m = '1;
        else
            m = (SSB_WORD_W'(1) << n) - SSB_WORD_W'(1);
        return m;
    endfunction

endpackage

// File: rtl/ssb_client_mux.sv
`timescale 1ns/1ps
module ssb_client_mux
    import ssb_pkg::*;
#(
    parameter int NC     = SSB_CLIENTS,
    parameter int WORD_W = SSB_WORD_W,
    parameter int LEN_W  = SSB_LEN_W,
    parameter int SEL_W  = SSB_SEL_W
) (
    input  logic [SEL_W-1:0]     sel,
    input  logic [NC-1:0]        push_vec,
    input  logic [NC-1:0]        pop_vec,
    input  logic [NC*LEN_W-1:0]  len_flat,
    input  logic [NC*WORD_W-1:0] word_flat,
    output client_req_t          req
);

    client_req_t lane [NC];

    generate
        for (genvar g = 0; g < NC; g++) begin : g_lane
            assign lane[g] = '{
                push: push_vec[g],
                pop:  pop_vec[g],
                len:  len_flat[g*LEN_W +: LEN_W],
                word: word_flat[g*WORD_W +: WORD_W]
            };
        end
    endgenerate

    assign req = lane[sel];

endmodule

// File: rtl/ssb_occupancy.sv
`timescale 1ns/1ps
module ssb_occupancy
    import ssb_pkg::*;
#(
    parameter int WORD_W = SSB_WORD_W,
    parameter int LEN_W  = SSB_LEN_W,
    parameter int LVL_W  = SSB_LVL_W,
    parameter int SEL_W  = SSB_SEL_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [SEL_W-1:0] sel,
    input  client_req_t      req,
    output step_t            step,
    output logic [LVL_W-1:0] level,
    output logic             push_ok,
    output logic             pop_ok
);

    localparam logic [LVL_W:0] WORD_EXT = (LVL_W+1)'(WORD_W);

    logic [SEL_W-1:0] sel_q;
    logic [LVL_W-1:0] level_q;
    logic             switching;
    logic             len_legal;
    logic [LVL_W-1:0] len_ext;
    logic [LVL_W:0]   win;
    logic [LVL_W:0]   after_pop;

    always_comb begin
        switching = (sel != sel_q);
        win       = window_of(client_e'(sel));
        len_ext   = {{(LVL_W-LEN_W){1'b0}}, req.len};
        len_legal = (req.len != '0) && (int'(req.len) <= WORD_W);

        pop_ok    = !rst && !switching && req.pop && len_legal && (level_q >= len_ext);
        after_pop = {1'b0, level_q} - (pop_ok ? {1'b0, len_ext} : '0);
        push_ok   = !rst && !switching && req.push && ((after_pop + WORD_EXT) <= win);

        step.clear   = switching;
        step.pop_go  = pop_ok;
        step.push_go = push_ok;
        step.len     = req.len;
        step.base    = after_pop[LVL_W-1:0];
        step.word    = req.word;
    end

    // Owner of the previous cycle, tracked through reset as well
    always_ff @(posedge clk) begin
        sel_q <= sel;
    end

    always_ff @(posedge clk) begin
        if (rst || switching)
            level_q <= '0;
        else
            level_q <= after_pop[LVL_W-1:0] + (push_ok ? LVL_W'(WORD_W) : '0);
    end

    assign level = level_q;

endmodule

// File: rtl/ssb_store.sv
`timescale 1ns/1ps
module ssb_store
    import ssb_pkg::*;
#(
    parameter int BUF_W  = SSB_BUF_W,
    parameter int WORD_W = SSB_WORD_W
) (
    input  logic              clk,
    input  logic              rst,
    input  step_t             step,
    output logic [WORD_W-1:0] field
);

    logic [BUF_W-1:0] bits_q;
    logic [BUF_W-1:0] drained;
    logic [BUF_W-1:0] placed;

    always_comb begin
        drained = step.pop_go ? (bits_q >> step.len) : bits_q;
        placed  = {{(BUF_W-WORD_W){1'b0}}, step.word} << step.base;
        field   = bits_q[WORD_W-1:0] & low_mask(step.len);
    end

    always_ff @(posedge clk) begin
        if (rst || step.clear)
            bits_q <= '0;
        else if (step.push_go)
            bits_q <= drained | placed;
        else
            bits_q <= drained;
    end

endmodule

// File: rtl/acc_shift_buf.sv
`timescale 1ns/1ps
module acc_shift_buf
    import ssb_pkg::*;
#(
    parameter int NC     = SSB_CLIENTS,
    parameter int WORD_W = SSB_WORD_W,
    parameter int BUF_W  = SSB_BUF_W,
    parameter int LEN_W  = SSB_LEN_W,
    parameter int LVL_W  = SSB_LVL_W,
    parameter int SEL_W  = SSB_SEL_W
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [SEL_W-1:0]     client_sel,
    input  logic [NC-1:0]        push_req,
    input  logic [NC-1:0]        pop_req,
    input  logic [NC*LEN_W-1:0]  pop_len,
    input  logic [NC*WORD_W-1:0] push_word,
    output logic [WORD_W-1:0]    field_out,
    output logic                 pop_ack,
    output logic                 push_ack,
    output logic [LVL_W-1:0]     fill_level
);

    client_req_t req;
    step_t       step;

    ssb_client_mux #(
        .NC(NC), .WORD_W(WORD_W), .LEN_W(LEN_W), .SEL_W(SEL_W)
    ) u_mux (
        .sel       (client_sel),
        .push_vec  (push_req),
        .pop_vec   (pop_req),
        .len_flat  (pop_len),
        .word_flat (push_word),
        .req       (req)
    );

    ssb_occupancy #(
        .WORD_W(WORD_W), .LEN_W(LEN_W), .LVL_W(LVL_W), .SEL_W(SEL_W)
    ) u_occ (
        .clk     (clk),
        .rst     (rst),
        .sel     (client_sel),
        .req     (req),
        .step    (step),
        .level   (fill_level),
        .push_ok (push_ack),
        .pop_ok  (pop_ack)
    );

    ssb_store #(
        .BUF_W(BUF_W), .WORD_W(WORD_W)
    ) u_store (
        .clk   (clk),
        .rst   (rst),
        .step  (step),
        .field (field_out)
    );

endmodule

// File: rtl/acc_shift_buf_chk.sv
`timescale 1ns/1ps
module acc_shift_buf_chk
    import ssb_pkg::*;
#(
    parameter int NC     = SSB_CLIENTS,
    parameter int WORD_W = SSB_WORD_W,
    parameter int LEN_W  = SSB_LEN_W,
    parameter int LVL_W  = SSB_LVL_W,
    parameter int SEL_W  = SSB_SEL_W
) (
    input logic                clk,
    input logic                rst,
    input logic [SEL_W-1:0]    client_sel,
    input logic [NC*LEN_W-1:0] pop_len,
    input logic                pop_ack,
    input logic                push_ack,
    input logic [LVL_W-1:0]    fill_level
);

    logic [LEN_W-1:0] sel_len;
    int               sel_win;

    assign sel_len = pop_len[client_sel*LEN_W +: LEN_W];
    assign sel_win = int'(window_of(client_e'(client_sel)));

    AST_RESET_EMPTY: assert property (@(posedge clk)
        rst |=> (fill_level == '0)) else $error("reset level");                                   // R1

    AST_RESET_NO_ACK: assert property (@(posedge clk)
        rst |-> (!push_ack && !pop_ack)) else $error("ack in reset");                             // R1

    AST_SWITCH_BLOCKS: assert property (@(posedge clk) disable iff (rst)
        !$stable(client_sel) |-> (!push_ack && !pop_ack)) else $error("ack on switch");          // R3

    AST_SWITCH_CLEARS: assert property (@(posedge clk) disable iff (rst)
        !$stable(client_sel) |=> (fill_level == '0)) else $error("switch not cleared");          // R3

    AST_PUSH_GROWS: assert property (@(posedge clk) disable iff (rst)
        (push_ack && !pop_ack) |=> (int'(fill_level) == int'($past(fill_level)) + WORD_W))
        else $error("push level");                                                                // R4

    AST_PUSH_ROOM: assert property (@(posedge clk) disable iff (rst)
        (push_ack && !pop_ack) |-> (int'(fill_level) + WORD_W <= sel_win))
        else $error("push over window");                                                          // R5

    AST_POP_SHRINKS: assert property (@(posedge clk) disable iff (rst)
        (pop_ack && !push_ack) |=> (int'(fill_level) == int'($past(fill_level)) - int'($past(sel_len))))
        else $error("pop level");                                                                 // R6

    AST_POP_GUARD: assert property (@(posedge clk) disable iff (rst)
        pop_ack |-> (sel_len != '0 && int'(sel_len) <= WORD_W && int'(sel_len) <= int'(fill_level)))
        else $error("illegal pop");                                                               // R7

    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
        (!push_ack && !pop_ack && $stable(client_sel)) |=> $stable(fill_level))
        else $error("idle level moved");                                                          // R7

    AST_BOTH_ORDER: assert property (@(posedge clk) disable iff (rst)
        (push_ack && pop_ack) |=>
            (int'(fill_level) == int'($past(fill_level)) - int'($past(sel_len)) + WORD_W))
        else $error("pop+push level");                                                            // R8

    AST_WINDOW_LIMIT: assert property (@(posedge clk) disable iff (rst)
        $stable(client_sel) |-> (int'(fill_level) <= sel_win)) else $error("over window");       // R9

endmodule

bind acc_shift_buf acc_shift_buf_chk #(
    .NC(NC), .WORD_W(WORD_W), .LEN_W(LEN_W), .LVL_W(LVL_W), .SEL_W(SEL_W)
) u_chk (
    .clk        (clk),
    .rst        (rst),
    .client_sel (client_sel),
    .pop_len    (pop_len),
    .pop_ack    (pop_ack),
    .push_ack   (push_ack),
    .fill_level (fill_level)
);

// File: tb/acc_shift_buf_test.sv
`timescale 1ns/1ps
module acc_shift_buf_test;
    import ssb_pkg::*;

    localparam int NC = SSB_CLIENTS;
    localparam int W  = SSB_WORD_W;
    localparam int LW = SSB_LEN_W;
    localparam int VW = SSB_LVL_W;
    localparam int SW = SSB_SEL_W;

    logic            clk = 1'b0;
    logic            rst;
    logic [SW-1:0]   client_sel;
    logic [NC-1:0]   push_req;
    logic [NC-1:0]   pop_req;
    logic [NC*LW-1:0] pop_len;
    logic [NC*W-1:0] push_word;
    logic [W-1:0]    field_out;
    logic            pop_ack;
    logic            push_ack;
    logic [VW-1:0]   fill_level;

    always #2.5 clk = ~clk;

    acc_shift_buf uut (
        .clk(clk), .rst(rst), .client_sel(client_sel), .push_req(push_req),
        .pop_req(pop_req), .pop_len(pop_len), .push_word(push_word),
        .field_out(field_out), .pop_ack(pop_ack), .push_ack(push_ack),
        .fill_level(fill_level)
    );

    bit q[$];
    int prev_sel;
    int checks = 0;
    int fails  = 0;

    function automatic int win(int c);
        case (c)
            0: return 64;
            1: return 320;
            2: return 320;
            default: return 676;
        endcase
    endfunction

    task automatic check(string tag, string ctx, logic [W-1:0] act, logic [W-1:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s (%s) actual=%h expected=%h", tag, ctx, act, exp);
        end
    endtask

    task automatic idle_all();
        push_req  = '0;
        pop_req   = '0;
        pop_len   = '0;
        push_word = '0;
    endtask

    task automatic put(int c, bit ps, bit po, int n, logic [W-1:0] w);
        push_req[c]          = ps;
        pop_req[c]           = po;
        pop_len[c*LW +: LW]  = LW'(n);
        push_word[c*W +: W]  = w;
    endtask

    // Inputs are set at the falling edge; compare, advance the model, then clock.
    task automatic tick(string ctx);
        int s, n, after;
        bit ps, po, sw, ep, eu;
        logic [W-1:0] ef, wd;
        string tp, tu;
        #1;
        s  = int'(client_sel);
        n  = int'(pop_len[s*LW +: LW]);
        ps = push_req[s];
        po = pop_req[s];
        wd = push_word[s*W +: W];
        sw = (s != prev_sel);
        ep = 0;
        eu = 0;
        if (!sw) begin
            ep    = po && n >= 1 && n <= W && q.size() >= n;
            after = q.size() - (ep ? n : 0);
            eu    = ps && (after + W <= win(s));
        end
        tp = sw ? "R3" : (ep ? "R6" : "R7");
        tu = sw ? "R3" : (eu ? "R4" : "R5");
        if (ep && eu) begin tp = "R8"; tu = "R8"; end
        check(tp, ctx, {63'd0, pop_ack}, {63'd0, ep});
        check(tu, ctx, {63'd0, push_ack}, {63'd0, eu});
        if (ep) begin
            ef = '0;
            for (int i = 0; i < n; i++) ef[i] = q[i];
            check(tp, ctx, field_out, ef);
        end
        if (sw) q.delete();
        else begin
            if (ep) for (int i = 0; i < n; i++) void'(q.pop_front());
            if (eu) for (int i = 0; i < W; i++) q.push_back(wd[i]);
        end
        prev_sel = s;
        @(posedge clk);
        @(negedge clk);
        check("R10", ctx, W'(fill_level), W'(q.size()));
    endtask

    task automatic op(int c, bit ps, bit po, int n, string ctx);
        idle_all();
        client_sel = SW'(c);
        put(c, ps, po, n, {$urandom, $urandom});
        tick(ctx);
    endtask

    initial begin
        #1000000;
        fails++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        int order[4];
        order = '{2, 0, 3, 1};
        rst = 1'b1;
        client_sel = '0;
        push_req = '1;
        pop_req = '1;
        pop_len = '1;
        push_word = '1;
        repeat (3) begin
            @(negedge clk);
            #1;
            check("R1", "acks in reset", {62'd0, push_ack, pop_ack}, 64'd0);
        end
        idle_all();
        prev_sel = 0;
        rst = 1'b0;
        check("R1", "level after reset", W'(fill_level), 64'd0);
        op(0, 0, 1, 1, "R1 pop after reset");

        idle_all();
        client_sel = '0;
        put(2, 1, 0, 0, 64'hDEAD_BEEF_0123_4567);
        put(1, 0, 1, 8, 64'h1);
        put(3, 1, 1, 4, 64'h2);
        tick("R2 others ignored");

        op(0, 1, 0, 0, "R4 first push");
        op(0, 1, 0, 0, "R9 rounder window 64 full");
        op(0, 0, 1, 8, "R6 pop 8");
        op(0, 1, 1, 8, "R8 pop leaves no room");
        op(0, 0, 1, 40, "R6 pop 40");
        op(0, 1, 1, 8, "R8 pop frees room");
        op(0, 0, 1, 0, "R7 width 0");
        op(0, 0, 1, 65, "R7 width 65");
        op(0, 0, 1, 64, "R6 pop 64");
        op(0, 0, 1, 1, "R7 empty pop");
        op(0, 1, 0, 0, "R4 refill");

        op(1, 1, 1, 4, "R3 switch with data");
        repeat (6) op(1, 1, 0, 0, "R9 packer window 320");
        for (int k = 1; k <= 20; k++) op(1, 0, 1, k, "R6 packer widths");
        op(1, 0, 1, 200, "R7 width over 64");

        op(3, 0, 0, 0, "R3 switch to multiplier");
        repeat (11) op(3, 1, 0, 0, "R9 multiplier fill");
        op(3, 0, 1, 28, "R6 pop 28");
        op(3, 1, 0, 0, "R9 multiplier at 676");
        op(3, 1, 0, 0, "R5 buffer full");
        repeat (11) op(3, 0, 1, 63, "R6 drain 63");

        for (int j = 0; j < 4; j++) begin
            repeat (600) begin
                idle_all();
                client_sel = SW'(order[j]);
                for (int k = 0; k < NC; k++)
                    put(k, ($urandom % 3) != 0, ($urandom % 2) != 0,
                        int'($urandom_range(0, 66)), {$urandom, $urandom});
                tick("R2 random traffic");
            end
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule